// File: doc/BRIEF.md
# I/O Byte-Lane Target-Abort Monitor

This block watches a PCI-style bus from the side and checks one protocol rule. An I/O read or I/O write must be refused with a target abort when its byte enables turn on a lane that lies below the byte address given by the two low address bits. The monitor never drives the bus. It samples the active-low control lines, the command/byte-enable lines and the two low address lines on the clock edges where the qualifying enable `qual_en` is high.

A check is armed when FRAME# is seen falling with an I/O command on the command lines. The low address bits are latched at that point. On the next qualified sample the byte enables are compared with the latched address. If they disagree, the monitor waits for the abort. The abort is DEVSEL# going high in the same sample where STOP# goes low. The check fails if any of the following happens first:
- a data transfer (TRDY# low);
- a disconnect (DEVSEL# and STOP# both low);
- DEVSEL# released without STOP#;
- the bus going idle.

Each verdict gives a one-clock pulse on the pass output or on the error output. Every error also sets a sticky violation flag.

Top module: `io_abort_mon`

## Requirements
- R1: A synchronous active-high `rst` returns the monitor to idle and clears `err_pulse`, `pass_pulse` and `viol_sticky` at the next clock edge. A transaction in progress is forgotten.
- R2: Tracking starts on a qualified sample where `frame_n` is 0 and was 1 on the previous qualified sample, and `cbe_n` equals 4'b0010 (I/O read) or 4'b0011 (I/O write). No other command ever yields a pass or an error.
- R3: `ad_lo` is latched on the start sample. On the next qualified sample the access is a mismatch when any lane n below the latched address has `cbe_n[n]` = 0 (enabled). Without a mismatch the monitor goes idle and reports nothing.
- R4: On a mismatched access, a sample where `devsel_n` rises (0 to 1) and `stop_n` falls (1 to 0) is a target abort. It raises `pass_pulse` for one clock after that edge.
- R5: On a mismatched access, `trdy_n` low before the abort raises `err_pulse`.
- R6: On a mismatched access, `devsel_n` and `stop_n` both low before the abort raises `err_pulse`.
- R7: On a mismatched access, `frame_n` and `irdy_n` both high before the abort raises `err_pulse`.
- R8: On a mismatched access, `devsel_n` rising while `stop_n` does not fall raises `err_pulse`.
- R9: `viol_sticky` is set together with every `err_pulse` and stays set until reset.
- R10: Each verdict is a single one-clock pulse. `err_pulse` and `pass_pulse` are never high together.
- R11: Clock edges with `qual_en` = 0 are ignored, whatever the bus lines show.
- R12: A FRAME# fall while an access is being tracked does not restart the monitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qual_en | input | 1 | Sample qualifier; the bus is observed only when high |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| devsel_n | input | 1 | DEVSEL#, active low |
| stop_n | input | 1 | STOP#, active low |
| cbe_n | input | BE_W | Command / byte-enable lines, active low enables |
| ad_lo | input | ADDR_W | Low address bits |
| err_pulse | output | 1 | One-clock rule-violation pulse |
| pass_pulse | output | 1 | One-clock abort-seen pulse |
| viol_sticky | output | 1 | Set by any violation, cleared by reset |

## Verification
The assertions check the following on every cycle:
- the two verdict pulses are one clock wide and never high together;
- the sticky flag never drops outside reset and is high whenever an error pulse is;
- the tracker state holds across unqualified edges;
- a FRAME# fall during tracking leaves the monitor waiting.

Only the bench's scenarios can show that the right verdict follows from each bus pattern. That covers the lane-by-lane byte-enable comparison, the order in which abort, data transfer, disconnect and idle compete, and that untracked commands stay silent. It also covers garbage shown on unqualified edges being ignored, and a reset in mid-transaction discarding the access.

// File: rtl/io_abort_pkg.sv
package io_abort_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_WAIT  = 2'd2
   } mon_state_e;

   typedef enum logic [1:0] {
      VD_NONE = 2'd0,
      VD_PASS = 2'd1,
      VD_FAIL = 2'd2
   } verdict_e;

endpackage

// File: rtl/io_abort_sampler.sv
module io_abort_sampler (
   input  logic clk,
   input  logic rst,
   input  logic qual_en,
   input  logic frame_n,
   input  logic devsel_n,
   input  logic stop_n,
   output logic frame_fall,
   output logic devsel_rise,
   output logic stop_fall
);
   logic frame_q, devsel_q, stop_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         frame_q  <= 1'b1;
         devsel_q <= 1'b1;
         stop_q   <= 1'b1;
      end else if (qual_en) begin
         frame_q  <= frame_n;
         devsel_q <= devsel_n;
         stop_q   <= stop_n;
      end
   end

   assign frame_fall  = frame_q & ~frame_n;
   assign devsel_rise = ~devsel_q & devsel_n;
   assign stop_fall   = stop_q & ~stop_n;

endmodule

// File: rtl/io_abort_decode.sv
module io_abort_decode #(
   parameter int              ADDR_W = 2,
   parameter int              BE_W   = 4,
   parameter logic [BE_W-1:0] CMD_RD = BE_W'(2),
   parameter logic [BE_W-1:0] CMD_WR = BE_W'(3)
) (
   input  logic [BE_W-1:0]   cbe_n,
   input  logic [ADDR_W-1:0] addr_q,
   output logic              is_io,
   output logic              mismatch
);
   logic [BE_W-1:0] lane_bad;

   assign is_io = (cbe_n == CMD_RD) || (cbe_n == CMD_WR);

   for (genvar g = 0; g < BE_W; g++) begin : g_lane
      assign lane_bad[g] = (ADDR_W'(g) < addr_q) && !cbe_n[g];
   end

   assign mismatch = |lane_bad;

endmodule

// File: rtl/io_abort_fsm.sv
module io_abort_fsm
   import io_abort_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              qual_en,
   input  logic              frame_fall,
   input  logic              devsel_rise,
   input  logic              stop_fall,
   input  logic              frame_n,
   input  logic              irdy_n,
   input  logic              trdy_n,
   input  logic              devsel_n,
   input  logic              stop_n,
   input  logic              is_io,
   input  logic              mismatch,
   input  logic [ADDR_W-1:0] ad_lo,
   output logic [ADDR_W-1:0] addr_q,
   output logic              err_o,
   output logic              pass_o,
   output logic              viol_o
);
   mon_state_e state_q;
   verdict_e   verdict;
   logic       tracking;

   assign tracking = (state_q == ST_WAIT) || (state_q == ST_ARMED && mismatch);

   always_comb begin
      verdict = VD_NONE;
      if (devsel_rise && stop_fall)
         verdict = VD_PASS;
      else if (!trdy_n || (!devsel_n && !stop_n) || devsel_rise || (frame_n && irdy_n))
         verdict = VD_FAIL;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         err_o   <= 1'b0;
         pass_o  <= 1'b0;
         viol_o  <= 1'b0;
      end else begin
         err_o  <= 1'b0;
         pass_o <= 1'b0;
         if (qual_en) begin
            unique case (state_q)
               ST_IDLE: begin
                  if (frame_fall && is_io) begin
                     addr_q  <= ad_lo;
                     state_q <= ST_ARMED;
                  end
               end
               ST_ARMED, ST_WAIT: begin
                  if (!tracking) begin
                     state_q <= ST_IDLE;
                  end else if (verdict == VD_PASS) begin
                     pass_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (verdict == VD_FAIL) begin
                     err_o   <= 1'b1;
                     viol_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_WAIT;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   AST_NO_DUAL_VERDICT: assert property (@(posedge clk) disable iff (rst)
      !(err_o && pass_o)); // R10
   AST_ERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
      err_o |=> !err_o); // R10
   AST_PASS_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
      pass_o |=> !pass_o); // R4
   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
      viol_o |=> viol_o); // R9
   AST_ERR_MARKS_STICKY: assert property (@(posedge clk) disable iff (rst)
      err_o |-> viol_o); // R9
   AST_UNQUAL_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !qual_en |=> $stable(state_q)); // R11
   AST_VERDICT_IDLES: assert property (@(posedge clk) disable iff (rst)
      (err_o || pass_o) |-> state_q == ST_IDLE); // R4
   AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_WAIT && qual_en && frame_fall && verdict == VD_NONE)
      |=> state_q == ST_WAIT); // R12

endmodule

// File: rtl/io_abort_mon.sv
module io_abort_mon #(
   parameter int              ADDR_W = 2,
   parameter int              BE_W   = 4,
   parameter logic [BE_W-1:0] CMD_RD = BE_W'(2),
   parameter logic [BE_W-1:0] CMD_WR = BE_W'(3)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              qual_en,
   input  logic              frame_n,
   input  logic              irdy_n,
   input  logic              trdy_n,
   input  logic              devsel_n,
   input  logic              stop_n,
   input  logic [BE_W-1:0]   cbe_n,
   input  logic [ADDR_W-1:0] ad_lo,
   output logic              err_pulse,
   output logic              pass_pulse,
   output logic              viol_sticky
);
   localparam int LANES = 1 << ADDR_W;

   if (BE_W != LANES) begin : g_bad_width
      $error("io_abort_mon: BE_W must equal 2**ADDR_W");
   end
   if (CMD_RD == CMD_WR) begin : g_bad_cmd
      $error("io_abort_mon: read and write command codes must differ");
   end

   logic              frame_fall, devsel_rise, stop_fall;
   logic              is_io, mismatch;
   logic [ADDR_W-1:0] addr_q;

   io_abort_sampler u_smp (
      .clk         (clk),
      .rst         (rst),
      .qual_en     (qual_en),
      .frame_n     (frame_n),
      .devsel_n    (devsel_n),
      .stop_n      (stop_n),
      .frame_fall  (frame_fall),
      .devsel_rise (devsel_rise),
      .stop_fall   (stop_fall)
   );

   io_abort_decode #(
      .ADDR_W (ADDR_W),
      .BE_W   (BE_W),
      .CMD_RD (CMD_RD),
      .CMD_WR (CMD_WR)
   ) u_dec (
      .cbe_n    (cbe_n),
      .addr_q   (addr_q),
      .is_io    (is_io),
      .mismatch (mismatch)
   );

   io_abort_fsm #(
      .ADDR_W (ADDR_W)
   ) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .qual_en     (qual_en),
      .frame_fall  (frame_fall),
      .devsel_rise (devsel_rise),
      .stop_fall   (stop_fall),
      .frame_n     (frame_n),
      .irdy_n      (irdy_n),
      .trdy_n      (trdy_n),
      .devsel_n    (devsel_n),
      .stop_n      (stop_n),
      .is_io       (is_io),
      .mismatch    (mismatch),
      .ad_lo       (ad_lo),
      .addr_q      (addr_q),
      .err_o       (err_pulse),
      .pass_o      (pass_pulse),
      .viol_o      (viol_sticky)
   );

endmodule

// File: tb/sim_io_abort_mon.sv
module sim_io_abort_mon;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] C_RD = 4'b0010;
   localparam logic [3:0] C_WR = 4'b0011;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       qual_en = 1'b1;
   logic       frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
   logic       devsel_n = 1'b1, stop_n = 1'b1;
   logic [3:0] cbe_n = 4'hF;
   logic [1:0] ad_lo = 2'd0;
   logic       err_pulse, pass_pulse, viol_sticky;

   int checks = 0;
   int errors = 0;
   int n_err = 0;
   int n_pass = 0;
   bit exp_viol = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   io_abort_mon u0 (
      .clk (clk), .rst (rst), .qual_en (qual_en),
      .frame_n (frame_n), .irdy_n (irdy_n), .trdy_n (trdy_n),
      .devsel_n (devsel_n), .stop_n (stop_n),
      .cbe_n (cbe_n), .ad_lo (ad_lo),
      .err_pulse (err_pulse), .pass_pulse (pass_pulse), .viol_sticky (viol_sticky)
   );

   function automatic bit f_is_io(input logic [3:0] c);
      return (c == C_RD) || (c == C_WR);
   endfunction

   // Lanes below the address must be disabled (cbe_n bit = 1).
   function automatic bit f_mismatch(input logic [1:0] a, input logic [3:0] be);
      logic [3:0] need;
      need = (4'd1 << a) - 4'd1;
      return (be & need) != need;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic q, input logic f, input logic i, input logic t,
                      input logic d, input logic s, input logic [3:0] cb,
                      input logic [1:0] a);
      @(negedge clk);
      qual_en = q; frame_n = f; irdy_n = i; trdy_n = t;
      devsel_n = d; stop_n = s; cbe_n = cb; ad_lo = a;
      @(posedge clk);
      #1;
      if (err_pulse) n_err++;
      if (pass_pulse) n_pass++;
      if (err_pulse && pass_pulse) check("R10 both pulses", 1, 0);
   endtask

   task automatic idle_cyc();
      cyc(1, 1, 1, 1, 1, 1, 4'hF, 2'd0);
   endtask

   // kind: 0 abort, 1 TRDY# first, 2 disconnect, 3 bus idle, 4 DEVSEL# released alone
   task automatic run_txn(input logic [3:0] cmd, input logic [1:0] a,
                          input logic [3:0] be, input int kind, input bit stall);
      bit tracked;
      string tag;
      n_err = 0; n_pass = 0;
      tracked = f_is_io(cmd) && f_mismatch(a, be);
      idle_cyc();
      cyc(1, 0, 1, 1, 1, 1, cmd, a);
      cyc(1, 1, 0, 1, (kind == 3) ? 1'b1 : 1'b0, 1, be, 2'd0);
      if (stall) cyc(0, 1, 1, 0, 0, 0, 4'h0, 2'd3); // R11 garbage on unqualified edge
      case (kind)
         0: cyc(1, 1, 0, 1, 1, 0, be, 2'd0);
         1: cyc(1, 1, 0, 0, 0, 1, be, 2'd0);
         2: cyc(1, 1, 0, 1, 0, 0, be, 2'd0);
         3: cyc(1, 1, 1, 1, 1, 1, be, 2'd0);
         default: cyc(1, 1, 0, 1, 1, 1, be, 2'd0);
      endcase
      idle_cyc();
      idle_cyc();
      case (kind)
         0: tag = "R4 abort";
         1: tag = "R5 trdy";
         2: tag = "R6 disconnect";
         3: tag = "R7 idle";
         default: tag = "R8 devsel release";
      endcase
      if (!tracked) tag = "R2 R3 untracked";
      if (stall) tag = {tag, " R11 stall"};
      check({tag, " pass count"}, n_pass, (tracked && kind == 0) ? 1 : 0);
      check({tag, " err count R10"}, n_err, (tracked && kind != 0) ? 1 : 0);
      if (tracked && kind != 0) exp_viol = 1'b1;
      check("R9 sticky", int'(viol_sticky), int'(exp_viol));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset err", int'(err_pulse), 0);
      check("R1 reset pass", int'(pass_pulse), 0);
      check("R1 reset sticky", int'(viol_sticky), 0);
      @(negedge clk); rst = 1'b0;

      // directed corner cases
      run_txn(C_RD, 2'd1, 4'b0000, 0, 0);   // R4 lane0 enabled -> abort expected
      run_txn(C_WR, 2'd2, 4'b1101, 1, 0);   // R5 lane1 enabled
      run_txn(C_RD, 2'd3, 4'b0111, 0, 0);   // R3 lanes 0..2 off -> no check
      run_txn(C_RD, 2'd3, 4'b1011, 2, 0);   // R6 lane2 enabled
      run_txn(C_WR, 2'd0, 4'b0000, 3, 0);   // R3 address 0 never mismatches
      run_txn(4'b0110, 2'd1, 4'b0000, 1, 0);// R2 memory read not tracked
      run_txn(C_WR, 2'd1, 4'b1110, 3, 0);   // R7
      run_txn(C_RD, 2'd2, 4'b0000, 4, 0);   // R8
      run_txn(C_RD, 2'd1, 4'b0000, 0, 1);   // R11 stalled abort

      // R12: second FRAME# fall while waiting must not restart
      n_err = 0; n_pass = 0;
      idle_cyc();
      cyc(1, 0, 1, 1, 1, 1, C_RD, 2'd3);
      cyc(1, 1, 0, 1, 0, 1, 4'b0000, 2'd0);
      cyc(1, 0, 0, 1, 0, 1, C_WR, 2'd0);
      cyc(1, 1, 0, 1, 1, 0, 4'b0000, 2'd0);
      idle_cyc();
      check("R12 busy restart pass", n_pass, 1);
      check("R12 busy restart err", n_err, 0);

      // R1: reset in mid-transaction discards it and clears sticky
      n_err = 0; n_pass = 0;
      idle_cyc();
      cyc(1, 0, 1, 1, 1, 1, C_WR, 2'd2);
      cyc(1, 1, 0, 1, 0, 1, 4'b0000, 2'd0);
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      check("R1 mid reset sticky", int'(viol_sticky), 0);
      @(negedge clk); rst = 1'b0;
      exp_viol = 1'b0;
      cyc(1, 1, 0, 1, 1, 0, 4'b0000, 2'd0);
      idle_cyc();
      check("R1 mid reset pass", n_pass, 0);
      check("R1 mid reset err", n_err, 0);

      // constrained random
      for (int k = 0; k < 120; k++) begin
         logic [3:0] cmd;
         int sel;
         sel = int'($urandom_range(0, 5));
         case (sel)
            0, 1: cmd = C_RD;
            2, 3: cmd = C_WR;
            4: cmd = 4'b0111;
            default: cmd = 4'($urandom);
         endcase
         run_txn(cmd, 2'($urandom), 4'($urandom), int'($urandom_range(0, 4)),
                 bit'($urandom_range(0, 3) == 0));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule